// File: doc/BRIEF.md
# SPI FIFO Status and Request Logic

This block sits beside the shifter and FIFOs of an SPI controller and turns their raw status into request lines. It watches end-of-frame pulses, the start of each transfer, the transmit and receive FIFO occupancy counts, whether the receive shift register is full, and whether the controller is a slave in SPI configuration. From these it keeps three sticky event flags (frame done, transmit starvation, receive overrun) and one live status (receive data waiting). Each of them drives a request output only while its own enable input is set.

The receive-waiting status can be sent to either a DMA request line or an interrupt line, chosen by a routing input. When the receive path is already full and another transfer starts, a policy input decides whether the new word is loaded into the shift register or thrown away. The block tells the shifter which of the two to do. A combined interrupt line gathers every enabled interrupt source.

Each sticky flag is a two-state machine with the states FLG_IDLE and FLG_HELD. Its transitions are named SET (FLG_IDLE to FLG_HELD on its set event) and CLEAR (FLG_HELD to FLG_IDLE on a clear strobe with no set event in the same cycle). The receive-waiting status is a two-state machine with the states DRN_EMPTY and DRN_PENDING. Its transitions are named FILL (count became non-zero) and DRAIN (count became zero), and it is re-evaluated every cycle.

Top module: `spi_flag_req`

## Requirements
- R1: One cycle after a cycle in which `frame_end` is 1, `tc_flag` is 1. `irq_tc` equals `tc_flag` AND `en_tc`.
- R2: `uf_flag` is set one cycle after a cycle with `frame_start`=1, `tx_count`=0, `is_slave`=1 and `spi_mode`=1. If `is_slave` or `spi_mode` is 0, or `tx_count` is non-zero, it is not set.
- R3: `irq_uf` equals `uf_flag` AND `en_uf`.
- R4: `drain_stat` is 1 exactly when `rx_count` was non-zero in the previous cycle. `dma_req` therefore drops one cycle after the count reaches zero.
- R5: With `en_drain`=1, `drain_to_dma`=1 routes `drain_stat` to `dma_req` and `drain_to_dma`=0 routes it to `irq_drain`. `dma_req` and `irq_drain` are never 1 together, and both are 0 while `en_drain`=0.
- R6: `of_flag` is set one cycle after a cycle with `frame_start`=1, `rx_count` equal to `RX_DEPTH` and `rx_shift_full`=1. `irq_of` equals `of_flag` AND `en_of`.
- R7: In the same cycle as `frame_start`, `rx_discard`=1 and `rx_capture`=0 when the overflow condition of R6 holds and `ovr_overwrite`=0. Otherwise `rx_capture`=1 and `rx_discard`=0. With no `frame_start`, both are 0.
- R8: `tc_flag`, `uf_flag` and `of_flag` stay 1 until their clear strobe (`clr_tc`, `clr_uf`, `clr_of`) is 1. The flag reads 0 one cycle after that strobe.
- R9: If a flag's set event and its clear strobe come in the same cycle, the flag is 1 in the next cycle.
- R10: `irq_any` is the OR of `irq_tc`, `irq_uf`, `irq_drain` and `irq_of`.
- R11: While `rst_n` is 0, every flag, `drain_stat` and every request output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end | input | 1 | Pulse at the end of a serial frame |
| frame_start | input | 1 | Pulse when a transfer begins |
| is_slave | input | 1 | 1 when the controller is a slave |
| spi_mode | input | 1 | 1 when in SPI configuration |
| tx_count | input | CNT_W | Transmit FIFO entry count |
| rx_count | input | CNT_W | Receive FIFO entry count |
| rx_shift_full | input | 1 | Receive shift register holds an unread word |
| en_tc | input | 1 | Frame-done request enable |
| en_uf | input | 1 | Transmit-starvation request enable |
| en_drain | input | 1 | Receive-waiting request enable |
| en_of | input | 1 | Receive-overrun request enable |
| drain_to_dma | input | 1 | 1 routes receive-waiting to DMA, 0 to interrupt |
| ovr_overwrite | input | 1 | 1 loads data on overrun, 0 drops it |
| clr_tc | input | 1 | Write-one-to-clear for tc_flag |
| clr_uf | input | 1 | Write-one-to-clear for uf_flag |
| clr_of | input | 1 | Write-one-to-clear for of_flag |
| tc_flag | output | 1 | Frame-done sticky flag |
| uf_flag | output | 1 | Transmit-starvation sticky flag |
| of_flag | output | 1 | Receive-overrun sticky flag |
| drain_stat | output | 1 | Receive data waiting (registered) |
| irq_tc | output | 1 | Frame-done interrupt |
| irq_uf | output | 1 | Starvation interrupt |
| irq_of | output | 1 | Overrun interrupt |
| irq_drain | output | 1 | Receive-waiting interrupt |
| dma_req | output | 1 | Receive-waiting DMA request |
| irq_any | output | 1 | OR of all enabled interrupts |
| rx_capture | output | 1 | Load incoming word into shift register |
| rx_discard | output | 1 | Drop incoming word |

## Verification
The three sticky flags and `drain_stat` pass through one register, so they are due on the first rising edge after their stimulus cycle. The bench samples them 1 ns after that edge. The request outputs and `irq_any` are combinational on those registered states and on the enables. `rx_capture` and `rx_discard` follow their inputs within the same cycle. For these, the bench drives the inputs 1 ns after an edge and samples before the next edge. The `dma_req` drop is checked twice: once while the old count still holds the register (expected 1), and again after the edge (expected 0).

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;
    typedef enum logic {FLG_IDLE, FLG_HELD} flag_state_e;
    typedef enum logic {DRN_EMPTY, DRN_PENDING} drain_state_e;
    localparam int NUM_STICKY = 3;
    localparam int IDX_TC = 0;
    localparam int IDX_UF = 1;
    localparam int IDX_OF = 2;
endpackage

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag
    import spi_req_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_i) state_d = FLG_HELD;               // SET
            FLG_HELD: if (clr_i && !set_i) state_d = FLG_IDLE;     // CLEAR, set wins
            default:  state_d = FLG_IDLE;
        endcase
    end

    always_comb flag_o = (state_q == FLG_HELD);
endmodule

// File: rtl/spi_evt_detect.sv
module spi_evt_detect
    import spi_req_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    parameter int CNT_W    = 3
) (
    input  logic                  frame_end,
    input  logic                  frame_start,
    input  logic                  is_slave,
    input  logic                  spi_mode,
    input  logic [CNT_W-1:0]      tx_count,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic                  rx_shift_full,
    input  logic                  ovr_overwrite,
    output logic [NUM_STICKY-1:0] set_vec,
    output logic                  rx_capture,
    output logic                  rx_discard
);
    localparam logic [CNT_W-1:0] RX_FULL_CNT = CNT_W'(RX_DEPTH);

    logic rx_path_full;
    logic starve_evt;
    logic overrun_evt;

    always_comb begin
        rx_path_full = (rx_count == RX_FULL_CNT) && rx_shift_full;
        starve_evt   = frame_start && is_slave && spi_mode && (tx_count == '0);
        overrun_evt  = frame_start && rx_path_full;

        set_vec         = '0;
        set_vec[IDX_TC] = frame_end;
        set_vec[IDX_UF] = starve_evt;
        set_vec[IDX_OF] = overrun_evt;

        rx_discard = overrun_evt && !ovr_overwrite;
        rx_capture = frame_start && !rx_discard;
    end
endmodule

// File: rtl/spi_req_route.sv
module spi_req_route
    import spi_req_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic [NUM_STICKY-1:0] flags,
    input  logic [NUM_STICKY-1:0] flag_en,
    input  logic                  en_drain,
    input  logic                  drain_to_dma,
    output logic                  drain_stat,
    output logic [NUM_STICKY-1:0] flag_irq,
    output logic                  irq_drain,
    output logic                  dma_req,
    output logic                  irq_any
);
    drain_state_e drn_q, drn_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drn_q <= DRN_EMPTY;
        else        drn_q <= drn_d;
    end

    always_comb begin
        drn_d = drn_q;
        unique case (drn_q)
            DRN_EMPTY:   if (rx_count != '0) drn_d = DRN_PENDING;  // FILL
            DRN_PENDING: if (rx_count == '0) drn_d = DRN_EMPTY;    // DRAIN
            default:     drn_d = DRN_EMPTY;
        endcase
    end

    logic drain_req;

    always_comb begin
        drain_stat = (drn_q == DRN_PENDING);
        drain_req  = drain_stat && en_drain;
        dma_req    = drain_req && drain_to_dma;
        irq_drain  = drain_req && !drain_to_dma;
    end

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_gate
        assign flag_irq[i] = flags[i] && flag_en[i];
    end

    assign irq_any = (|flag_irq) || irq_drain;
endmodule

// File: rtl/spi_flag_req.sv
module spi_flag_req
    import spi_req_pkg::*;
#(
    parameter  int RX_DEPTH = 4,
    parameter  int TX_DEPTH = 4,
    localparam int MAX_DEPTH = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
    localparam int CNT_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end,
    input  logic             frame_start,
    input  logic             is_slave,
    input  logic             spi_mode,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_shift_full,
    input  logic             en_tc,
    input  logic             en_uf,
    input  logic             en_drain,
    input  logic             en_of,
    input  logic             drain_to_dma,
    input  logic             ovr_overwrite,
    input  logic             clr_tc,
    input  logic             clr_uf,
    input  logic             clr_of,
    output logic             tc_flag,
    output logic             uf_flag,
    output logic             of_flag,
    output logic             drain_stat,
    output logic             irq_tc,
    output logic             irq_uf,
    output logic             irq_of,
    output logic             irq_drain,
    output logic             dma_req,
    output logic             irq_any,
    output logic             rx_capture,
    output logic             rx_discard
);
    logic [NUM_STICKY-1:0] set_vec, clr_vec, flag_vec, en_vec, irq_vec;

    assign clr_vec[IDX_TC] = clr_tc;
    assign clr_vec[IDX_UF] = clr_uf;
    assign clr_vec[IDX_OF] = clr_of;
    assign en_vec[IDX_TC]  = en_tc;
    assign en_vec[IDX_UF]  = en_uf;
    assign en_vec[IDX_OF]  = en_of;

    spi_evt_detect #(.RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_evt (
        .frame_end     (frame_end),
        .frame_start   (frame_start),
        .is_slave      (is_slave),
        .spi_mode      (spi_mode),
        .tx_count      (tx_count),
        .rx_count      (rx_count),
        .rx_shift_full (rx_shift_full),
        .ovr_overwrite (ovr_overwrite),
        .set_vec       (set_vec),
        .rx_capture    (rx_capture),
        .rx_discard    (rx_discard)
    );

    for (genvar i = 0; i < NUM_STICKY; i++) begin : g_flag
        spi_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flag_vec[i])
        );
    end

    spi_req_route #(.CNT_W(CNT_W)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_count     (rx_count),
        .flags        (flag_vec),
        .flag_en      (en_vec),
        .en_drain     (en_drain),
        .drain_to_dma (drain_to_dma),
        .drain_stat   (drain_stat),
        .flag_irq     (irq_vec),
        .irq_drain    (irq_drain),
        .dma_req      (dma_req),
        .irq_any      (irq_any)
    );

    assign tc_flag = flag_vec[IDX_TC];
    assign uf_flag = flag_vec[IDX_UF];
    assign of_flag = flag_vec[IDX_OF];
    assign irq_tc  = irq_vec[IDX_TC];
    assign irq_uf  = irq_vec[IDX_UF];
    assign irq_of  = irq_vec[IDX_OF];
endmodule

// File: rtl/spi_flag_req_chk.sv
module spi_flag_req_chk #(
    parameter int RX_DEPTH = 4,
    parameter int CNT_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_end,
    input logic             frame_start,
    input logic             is_slave,
    input logic             spi_mode,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             rx_shift_full,
    input logic             ovr_overwrite,
    input logic             clr_tc,
    input logic             clr_of,
    input logic             tc_flag,
    input logic             uf_flag,
    input logic             of_flag,
    input logic             irq_drain,
    input logic             dma_req,
    input logic             rx_capture,
    input logic             rx_discard
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(RX_DEPTH);

    a_r1_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> tc_flag);

    a_r2_uf_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf_flag) |-> $past(frame_start && is_slave && spi_mode && (tx_count == '0)));

    a_r4_dma_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> !dma_req);

    a_r5_route_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_req && irq_drain));

    a_r7_drop_policy: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && rx_count == FULL && rx_shift_full && !ovr_overwrite)
            |-> (rx_discard && !rx_capture));

    a_r8_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_flag && !clr_tc) |=> tc_flag);

    a_r9_of_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_of && frame_start && rx_count == FULL && rx_shift_full) |=> of_flag);
endmodule

bind spi_flag_req spi_flag_req_chk #(.RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_start(frame_start),
    .is_slave(is_slave), .spi_mode(spi_mode), .tx_count(tx_count), .rx_count(rx_count),
    .rx_shift_full(rx_shift_full), .ovr_overwrite(ovr_overwrite), .clr_tc(clr_tc),
    .clr_of(clr_of), .tc_flag(tc_flag), .uf_flag(uf_flag), .of_flag(of_flag),
    .irq_drain(irq_drain), .dma_req(dma_req), .rx_capture(rx_capture),
    .rx_discard(rx_discard)
);

// File: tb/spi_flag_req_tb.sv
module spi_flag_req_tb;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_end = 0, frame_start = 0, is_slave = 0, spi_mode = 0;
    logic [CW-1:0] tx_count = '0, rx_count = '0;
    logic rx_shift_full = 0;
    logic en_tc = 0, en_uf = 0, en_drain = 0, en_of = 0;
    logic drain_to_dma = 0, ovr_overwrite = 0;
    logic clr_tc = 0, clr_uf = 0, clr_of = 0;
    logic tc_flag, uf_flag, of_flag, drain_stat;
    logic irq_tc, irq_uf, irq_of, irq_drain, dma_req, irq_any;
    logic rx_capture, rx_discard;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_flag_req #(.RX_DEPTH(4), .TX_DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .frame_start(frame_start),
        .is_slave(is_slave), .spi_mode(spi_mode), .tx_count(tx_count), .rx_count(rx_count),
        .rx_shift_full(rx_shift_full), .en_tc(en_tc), .en_uf(en_uf), .en_drain(en_drain),
        .en_of(en_of), .drain_to_dma(drain_to_dma), .ovr_overwrite(ovr_overwrite),
        .clr_tc(clr_tc), .clr_uf(clr_uf), .clr_of(clr_of),
        .tc_flag(tc_flag), .uf_flag(uf_flag), .of_flag(of_flag), .drain_stat(drain_stat),
        .irq_tc(irq_tc), .irq_uf(irq_uf), .irq_of(irq_of), .irq_drain(irq_drain),
        .dma_req(dma_req), .irq_any(irq_any), .rx_capture(rx_capture), .rx_discard(rx_discard)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic test_reset();
        check("R11 tc_flag", tc_flag, 1'b0);
        check("R11 uf_flag", uf_flag, 1'b0);
        check("R11 of_flag", of_flag, 1'b0);
        check("R11 drain_stat", drain_stat, 1'b0);
        check("R11 dma_req", dma_req, 1'b0);
        check("R11 irq_any", irq_any, 1'b0);
    endtask

    task automatic test_frame_done();
        en_tc = 0;
        frame_end = 1; tick(); frame_end = 0;
        check("R1 tc_flag set", tc_flag, 1'b1);
        check("R1 irq_tc gated off", irq_tc, 1'b0);
        en_tc = 1; settle();
        check("R1 irq_tc enabled", irq_tc, 1'b1);
        check("R10 irq_any from tc", irq_any, 1'b1);
        tick(); tick();
        check("R8 tc_flag held", tc_flag, 1'b1);
        clr_tc = 1; tick(); clr_tc = 0;
        check("R8 tc_flag cleared", tc_flag, 1'b0);
        check("R10 irq_any idle", irq_any, 1'b0);
        frame_end = 1; clr_tc = 1; tick(); frame_end = 0; clr_tc = 0;
        check("R9 tc set wins", tc_flag, 1'b1);
        clr_tc = 1; tick(); clr_tc = 0;
        en_tc = 0;
    endtask

    task automatic test_starve();
        tx_count = '0; rx_count = '0;
        is_slave = 0; spi_mode = 1;
        frame_start = 1; tick(); frame_start = 0;
        check("R2 no uf as master", uf_flag, 1'b0);
        is_slave = 1; spi_mode = 0;
        frame_start = 1; tick(); frame_start = 0;
        check("R2 no uf outside SPI", uf_flag, 1'b0);
        spi_mode = 1; tx_count = 3'd2;
        frame_start = 1; tick(); frame_start = 0;
        check("R2 no uf with data", uf_flag, 1'b0);
        tx_count = '0;
        frame_start = 1; tick(); frame_start = 0;
        check("R2 uf set", uf_flag, 1'b1);
        check("R3 irq_uf gated off", irq_uf, 1'b0);
        en_uf = 1; settle();
        check("R3 irq_uf enabled", irq_uf, 1'b1);
        clr_uf = 1; tick(); clr_uf = 0;
        check("R8 uf cleared", uf_flag, 1'b0);
        en_uf = 0; is_slave = 0; spi_mode = 0;
    endtask

    task automatic test_drain();
        en_drain = 1; drain_to_dma = 1; rx_count = 3'd2; settle();
        check("R4 drain not yet", drain_stat, 1'b0);
        tick();
        check("R4 drain_stat", drain_stat, 1'b1);
        check("R5 dma_req", dma_req, 1'b1);
        check("R5 no irq_drain", irq_drain, 1'b0);
        drain_to_dma = 0; settle();
        check("R5 irq_drain", irq_drain, 1'b1);
        check("R5 dma off", dma_req, 1'b0);
        check("R10 irq_any drain", irq_any, 1'b1);
        en_drain = 0; settle();
        check("R5 disabled irq", irq_drain, 1'b0);
        check("R5 disabled dma", dma_req, 1'b0);
        en_drain = 1; drain_to_dma = 1; rx_count = '0; settle();
        check("R4 dma before edge", dma_req, 1'b1);
        tick();
        check("R4 dma dropped", dma_req, 1'b0);
        check("R4 drain_stat low", drain_stat, 1'b0);
        en_drain = 0; drain_to_dma = 0;
    endtask

    task automatic test_overrun();
        rx_count = 3'd4; rx_shift_full = 1; ovr_overwrite = 0;
        frame_start = 1; settle();
        check("R7 discard", rx_discard, 1'b1);
        check("R7 no capture", rx_capture, 1'b0);
        ovr_overwrite = 1; settle();
        check("R7 overwrite capture", rx_capture, 1'b1);
        check("R7 overwrite no discard", rx_discard, 1'b0);
        tick(); frame_start = 0;
        check("R6 of_flag", of_flag, 1'b1);
        check("R6 irq_of gated off", irq_of, 1'b0);
        en_of = 1; settle();
        check("R6 irq_of on", irq_of, 1'b1);
        clr_of = 1; frame_start = 1; tick(); clr_of = 0; frame_start = 0;
        check("R9 of set wins", of_flag, 1'b1);
        clr_of = 1; tick(); clr_of = 0;
        check("R8 of cleared", of_flag, 1'b0);
        rx_count = 3'd3; ovr_overwrite = 0; frame_start = 1; settle();
        check("R7 normal capture", rx_capture, 1'b1);
        check("R7 normal no discard", rx_discard, 1'b0);
        tick(); frame_start = 0;
        check("R6 no of below full", of_flag, 1'b0);
        settle();
        check("R7 idle no capture", rx_capture, 1'b0);
        rx_count = '0; rx_shift_full = 0; en_of = 0; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #3;
        test_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick();
        test_reset();
        test_frame_done();
        test_starve();
        test_drain();
        test_overrun();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule